// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Decoder

This block is the digital front end of a two-channel converter. A host writes 16-bit command words over a three-wire serial port: an active-low select, a serial clock and a data line. The block resamples these three pins in its own system clock domain, which must run at least four times faster than the serial clock. It assembles each word most significant bit first and decodes the four program bits. It then routes the 12 data bits to channel A, to channel B, to a holding buffer or to the reference-select field.

The holding buffer lets a host stage a new value for channel B and later move it out in the same cycle as a new value for channel A, so both outputs change together. Every complete word also sets the speed-mode flag and the power-down flag, whatever its target. A word that is cut short by the select rising has no effect. A one-cycle strobe marks each cycle in which the channel registers are loaded.

Top module: `dual_dac_regctl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) both channel codes, the holding buffer, fast_mode, power_down, ref_sel and upd_strobe are all zero.
- R2: A transfer starts on a falling edge of sel_n. Then sdin is sampled on each falling edge of sclk, the first bit being word bit 15. Word bit 15 is address bit high, bit 14 is the speed bit (1 = fast), bit 13 is the power bit (1 = power down), bit 12 is address bit low, and bits 11..0 are data.
- R3: Address 00 loads the data into channel B and into the holding buffer, and leaves channel A unchanged.
- R4: Address 01 loads the data into the holding buffer only. Neither channel code changes and no strobe is produced.
- R5: Address 10 loads the data into channel A and copies the holding buffer into channel B, both in the same clock cycle.
- R6: Address 11 sets ref_sel to data bits 1..0 and leaves both channels unchanged. Data bits 11..2 have no effect.
- R7: Every complete word, at any address, copies its speed bit to fast_mode and its power bit to power_down.
- R8: If sel_n rises before the 16th sampled bit, the partial word is discarded and no output or buffer changes.
- R9: After the 16th bit, further sclk falling edges are ignored until sel_n rises and falls again.
- R10: upd_strobe is high for exactly one cycle, in the cycle the new channel values appear, for each word at address 00 or 10, and at no other time.
- R11: While sel_n stays high, toggling sclk or sdin changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, data sampled on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| ch_a_code | output | 12 | Channel A code |
| ch_b_code | output | 12 | Channel B code |
| fast_mode | output | 1 | Speed flag from the latest complete word |
| power_down | output | 1 | Power-down flag from the latest complete word |
| ref_sel | output | 2 | Reference select: 00/11 external, 01 low internal, 10 high internal |
| upd_strobe | output | 1 | One-cycle pulse when the channel registers load |

## Verification
The hardest case to reach from the ports is the combined transfer. Channel A and channel B must change in the same cycle, and the value for B has to come from a buffer that an earlier buffer-only word filled without any visible effect. The stimulus first writes the buffer with an address 01 word and confirms that no output moved. It then sends an address 10 word, and the strobe monitor compares both channel codes in the one strobe cycle against the value staged earlier. Aborted words cut at 10 and 15 bits, and surplus clocks after a full word, show that only complete words reach the registers.

// File: rtl/dac_regctl_pkg.sv
`timescale 1ns/1ps
// Package: shared command-word layout and address decode for the DAC
// command decoder. Assumes the 4 program bits occupy the top of the word.
package dac_regctl_pkg;
    // Number of program bits in front of the data field
    localparam int unsigned PROG_BITS = 4;

    // Target selected by the two address bits
    typedef enum logic [1:0] {
        TGT_B_AND_BUF = 2'b00,
        TGT_BUF_ONLY  = 2'b01,
        TGT_A_XFER_B  = 2'b10,
        TGT_CONTROL   = 2'b11
    } target_e;

    // Reset value of the synchronized pin bundle {sel_n, sclk, sdin}
    localparam logic [2:0] PINS_IDLE = 3'b110;
endpackage

// File: rtl/dac_serial_sync.sv
`timescale 1ns/1ps
// Module: dac_serial_sync
// Resamples the three serial pins into the system clock domain and detects
// select and clock edges. Assumes clk runs at least 4x sclk, so every sclk
// level lasts longer than the synchronizer.
module dac_serial_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_i,
    input  logic sclk_i,
    input  logic sdin_i,
    output logic sel_low,
    output logic sel_fall,
    output logic sclk_fall,
    output logic sdin_s
);
    import dac_regctl_pkg::*;

    logic [2:0] stage_q [STAGES];
    logic [2:0] prev_q;
    logic [2:0] cur;

    // Synchronizer chain for the pin bundle plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= PINS_IDLE;
            prev_q <= PINS_IDLE;
        end else begin
            stage_q[0] <= {sel_n_i, sclk_i, sdin_i};
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    // Edge and level decode of the synchronized pins
    always_comb begin
        cur       = stage_q[STAGES-1];
        sel_low   = ~cur[2];
        sel_fall  = prev_q[2] & ~cur[2];
        sclk_fall = prev_q[1] & ~cur[1];
        sdin_s    = cur[0];
    end
endmodule

// File: rtl/dac_word_shifter.sv
`timescale 1ns/1ps
// Module: dac_word_shifter
// Assembles one command word MSB first. A select fall arms it; it stops after
// WORD_W bits and pulses word_valid. A select rise before that discards the
// partial word. Surplus clocks after a full word are ignored.
module dac_word_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_fall,
    input  logic              sel_low,
    input  logic              sclk_fall,
    input  logic              sdin_s,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_q
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    // Arm on select fall, shift on clock fall, finish on the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            cnt_q      <= '0;
            word_q     <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (sel_fall) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (!sel_low) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (armed_q && sclk_fall) begin
                word_q <= {word_q[WORD_W-2:0], sdin_s};
                if (cnt_q == LAST_BIT) begin
                    armed_q    <= 1'b0;
                    cnt_q      <= '0;
                    word_valid <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dac_latch_bank.sv
`timescale 1ns/1ps
// Module: dac_latch_bank
// Decodes a completed word and loads the channel, buffer and control
// registers. Assumes word_valid is a single-cycle pulse with word stable.
module dac_latch_bank #(
    parameter int unsigned DATA_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_valid,
    input  logic [DATA_W+3:0]    word,
    output logic [DATA_W-1:0]    ch_a_code,
    output logic [DATA_W-1:0]    ch_b_code,
    output logic                 fast_mode,
    output logic                 power_down,
    output logic [1:0]           ref_sel,
    output logic                 upd_strobe
);
    import dac_regctl_pkg::*;

    localparam int unsigned WORD_W = DATA_W + PROG_BITS;
    localparam int unsigned ADR_HI = WORD_W - 1;
    localparam int unsigned SPD_B  = WORD_W - 2;
    localparam int unsigned PWR_B  = WORD_W - 3;
    localparam int unsigned ADR_LO = WORD_W - 4;

    target_e           tgt;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] buf_q;

    // Field extraction from the completed word
    always_comb begin
        tgt  = target_e'({word[ADR_HI], word[ADR_LO]});
        data = word[DATA_W-1:0];
    end

    // Register update on a completed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_a_code  <= '0;
            ch_b_code  <= '0;
            buf_q      <= '0;
            fast_mode  <= 1'b0;
            power_down <= 1'b0;
            ref_sel    <= 2'b00;
            upd_strobe <= 1'b0;
        end else begin
            upd_strobe <= 1'b0;
            if (word_valid) begin
                fast_mode  <= word[SPD_B];
                power_down <= word[PWR_B];
                case (tgt)
                    TGT_B_AND_BUF: begin
                        ch_b_code  <= data;
                        buf_q      <= data;
                        upd_strobe <= 1'b1;
                    end
                    TGT_BUF_ONLY: buf_q <= data;
                    TGT_A_XFER_B: begin
                        ch_a_code  <= data;
                        ch_b_code  <= buf_q;
                        upd_strobe <= 1'b1;
                    end
                    default: ref_sel <= data[1:0];
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_dac_regctl.sv
`timescale 1ns/1ps
// Module: dual_dac_regctl
// Top of the serial command decoder for a two-channel DAC: synchronizer,
// word shifter and register bank. Assumes clk is at least 4x sclk.
module dual_dac_regctl #(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [DATA_W-1:0] ch_a_code,
    output logic [DATA_W-1:0] ch_b_code,
    output logic              fast_mode,
    output logic              power_down,
    output logic [1:0]        ref_sel,
    output logic              upd_strobe
);
    import dac_regctl_pkg::*;

    localparam int unsigned WORD_W = DATA_W + PROG_BITS;

    logic              sel_low, sel_fall, sclk_fall, sdin_s;
    logic              word_valid;
    logic [WORD_W-1:0] word_q;

    dac_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sel_n_i(sel_n), .sclk_i(sclk), .sdin_i(sdin),
        .sel_low(sel_low), .sel_fall(sel_fall),
        .sclk_fall(sclk_fall), .sdin_s(sdin_s)
    );

    dac_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sel_fall(sel_fall), .sel_low(sel_low),
        .sclk_fall(sclk_fall), .sdin_s(sdin_s),
        .word_valid(word_valid), .word_q(word_q)
    );

    dac_latch_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word(word_q),
        .ch_a_code(ch_a_code), .ch_b_code(ch_b_code),
        .fast_mode(fast_mode), .power_down(power_down),
        .ref_sel(ref_sel), .upd_strobe(upd_strobe)
    );
endmodule

// File: rtl/dual_dac_regctl_chk.sv
`timescale 1ns/1ps
// Module: dual_dac_regctl_chk
// Port-level properties of the command decoder, attached by bind.
module dual_dac_regctl_chk #(
    parameter int unsigned DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic [DATA_W-1:0] ch_a_code,
    input logic [DATA_W-1:0] ch_b_code,
    input logic              fast_mode,
    input logic              power_down,
    input logic [1:0]        ref_sel,
    input logic              upd_strobe
);
    logic [3:0] since_rst;

    // Cycles since reset release, saturating, to guard $past windows
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 4'hF) since_rst <= since_rst + 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (ch_a_code == '0 && ch_b_code == '0 && !fast_mode &&
                    !power_down && ref_sel == 2'b00 && !upd_strobe)); // R1

    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd1 && (ch_a_code != $past(ch_a_code) ||
                               ch_b_code != $past(ch_b_code))) |-> upd_strobe); // R10

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> !upd_strobe); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd7 && sel_n && $past(sel_n, 1) && $past(sel_n, 2) &&
         $past(sel_n, 3) && $past(sel_n, 4) && $past(sel_n, 5) && $past(sel_n, 6))
        |-> ($stable(ch_a_code) && $stable(ch_b_code) && $stable(ref_sel) &&
             $stable(fast_mode) && $stable(power_down))); // R11
endmodule

bind dual_dac_regctl dual_dac_regctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n),
    .ch_a_code(ch_a_code), .ch_b_code(ch_b_code),
    .fast_mode(fast_mode), .power_down(power_down),
    .ref_sel(ref_sel), .upd_strobe(upd_strobe)
);

// File: tb/dual_dac_regctl_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected channel loads, checked at each strobe, plus
// a register-state check after every serial transfer.
module dual_dac_regctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdin = 1'b0;
    logic [11:0] ch_a_code, ch_b_code;
    logic        fast_mode, power_down, upd_strobe;
    logic [1:0]  ref_sel;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    int seen = 0;
    bit done = 0;

    logic [11:0] m_a = '0, m_b = '0, m_buf = '0;
    logic        m_fast = 1'b0, m_pd = 1'b0;
    logic [1:0]  m_ref = 2'b00;
    logic [23:0] exp_q [$];

    always #2.5 clk = ~clk;

    dual_dac_regctl u_dual_dac_regctl (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
        .ch_a_code(ch_a_code), .ch_b_code(ch_b_code),
        .fast_mode(fast_mode), .power_down(power_down),
        .ref_sel(ref_sel), .upd_strobe(upd_strobe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk(req, "ch_a_code", 32'(ch_a_code), 32'(m_a));
        chk(req, "ch_b_code", 32'(ch_b_code), 32'(m_b));
        chk(req, "fast_mode", 32'(fast_mode), 32'(m_fast));
        chk(req, "power_down", 32'(power_down), 32'(m_pd));
        chk(req, "ref_sel", 32'(ref_sel), 32'(m_ref));
    endtask

    // Driver: updates the model, queues expected loads, drives the pins
    task automatic send(input logic [15:0] w, input int nbits,
                        input int extra, input logic [15:0] junk);
        if (nbits == 16) begin
            m_fast = w[14];
            m_pd   = w[13];
            case ({w[15], w[12]})
                2'b00: begin m_b = w[11:0]; m_buf = w[11:0];
                             exp_q.push_back({m_a, m_b}); pushed++; end
                2'b01: m_buf = w[11:0];
                2'b10: begin m_a = w[11:0]; m_b = m_buf;
                             exp_q.push_back({m_a, m_b}); pushed++; end
                default: m_ref = w[1:0];
            endcase
        end
        @(negedge clk);
        sel_n = 1'b0;
        #40;
        for (int i = 0; i < nbits; i++) begin
            sdin = w[15-i]; #20 sclk = 1'b0; #40 sclk = 1'b1; #20;
        end
        for (int i = 0; i < extra; i++) begin
            sdin = junk[15-i]; #20 sclk = 1'b0; #40 sclk = 1'b1; #20;
        end
        #40 sel_n = 1'b1;
        #200;
    endtask

    // Clock and data toggling with the select held high
    task automatic idle_noise();
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            sdin = i[0]; #20 sclk = 1'b0; #40 sclk = 1'b1; #20;
        end
        #200;
    endtask

    // Monitor: each strobe pops one expected {A,B} pair and compares it
    always @(negedge clk) begin
        if (rst_n && upd_strobe) begin
            seen++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected strobe: actual A=%h B=%h expected no strobe",
                         ch_a_code, ch_b_code);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk("R5/R10", "strobe {A,B}", 32'({ch_a_code, ch_b_code}), 32'(e));
            end
        end
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check_state("R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_state("R1");

        send(16'h0ABC, 16, 0, 16'h0);  check_state("R3");
        send(16'hC123, 16, 0, 16'h0);  check_state("R5");
        send(16'h1555, 16, 0, 16'h0);  check_state("R4");
        send(16'h8777, 16, 0, 16'h0);  check_state("R5");
        send(16'hDFFE, 16, 0, 16'h0);  check_state("R6");
        send(16'h9001, 16, 0, 16'h0);  check_state("R6");
        send(16'h3222, 16, 0, 16'h0);  check_state("R7");
        send(16'h6333, 16, 0, 16'h0);  check_state("R7");
        send(16'h8FFF, 10, 0, 16'h0);  check_state("R8");
        send(16'h0EEE, 15, 0, 16'h0);  check_state("R8");
        send(16'h0444, 16, 8, 16'hFFFF); check_state("R9");
        send(16'h8999, 16, 0, 16'h0);  check_state("R9");
        send(16'h8001, 16, 0, 16'h0);  check_state("R2");
        send(16'h8800, 16, 0, 16'h0);  check_state("R2");
        idle_noise();                  check_state("R11");

        chk("R10", "strobe count", 32'(seen), 32'(pushed));
        chk("R10", "queue left", 32'(exp_q.size()), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule